// File: doc/BRIEF.md
# Instruction Length Detector and Parcel Assembler

This block sits at the front of an instruction fetch path that carries a variable-length instruction set. Instruction bytes arrive in big-endian order as a stream of 16-bit parcels. The block reads the 6-bit major opcode in the upper bits of the first parcel of each instruction. From that opcode alone it decides how long the instruction is. It then collects the right number of parcels and hands the assembled instruction to the decoder, together with a length class. Big-endian order is needed because it places the opcode in the first parcel for every length. Only then can the length be known before the rest of the instruction arrives.

An escape row of eight opcodes (values 0 to 7) is split into four pairs. Each pair selects one alternative length. The low bit of the opcode pair is a free payload bit, so each escape class keeps 11 bits beyond the row selector. Every other opcode is an ordinary 32-bit instruction. An enable input switches the escape classification on or off. The start of a variable-length block is passed on as a single parcel with a block flag, and the rest of the block is parsed downstream. A flush input drops any partly assembled instruction so that the next parcel starts a new one.

Top module: `insn_len_detect`

## Requirements
- R1: With `esc_en` high, the major opcode is `in_parcel[15:10]` of the first parcel. Opcodes 0 and 1 give class 0 (16-bit, 1 parcel), 2 and 3 give class 2 (48-bit, 3 parcels), and 4 and 5 give class 3 (64-bit, 4 parcels).
- R2: With `esc_en` high, any opcode from 8 to 63 gives class 1 (32-bit, 2 parcels).
- R3: With `esc_en` low, every instruction is class 1 and takes 2 parcels, whatever its opcode.
- R4: `esc_en` is sampled only in the cycle the first parcel is accepted. A change during the later parcels does not alter the length.
- R5: `out_insn` carries the first parcel in bits 63:48 and each following parcel in the next lower 16 bits. Bits beyond the instruction length are zero, and `out_len` gives the parcel count (1 to 4).
- R6: `out_valid` rises only once all parcels of the instruction are held. Opcodes 6 and 7 (with `esc_en` high) give class 4, which is emitted after its first parcel with `out_len` = 1 and `out_block` high. `out_block` is high for class 4 only.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output instruction, class and length stay unchanged.
- R8: When `out_valid` and `out_ready` are both high without flush, `in_ready` is high. A parcel accepted in that cycle is the first parcel of the next instruction.
- R9: While `flush` is high, `in_ready` and `out_valid` are low. Any held or partial instruction is discarded, and the next accepted parcel is treated as a first parcel.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| esc_en | input | 1 | Enables escape-row length classification |
| flush | input | 1 | Discards any partial or held instruction |
| in_valid | input | 1 | Parcel present on `in_parcel` |
| in_ready | output | 1 | Block accepts the parcel this cycle |
| in_parcel | input | 16 | Next 16-bit parcel of the big-endian stream |
| out_valid | output | 1 | Assembled instruction available |
| out_ready | input | 1 | Consumer takes the instruction this cycle |
| out_insn | output | 64 | Instruction, left-aligned, unused bits zero |
| out_class | output | 3 | Length class: 0=16, 1=32, 2=48, 3=64, 4=block start |
| out_len | output | 3 | Number of parcels in `out_insn` |
| out_block | output | 1 | Marks a variable-length block start |

## Verification
Two things can happen in the same clock edge: handing off a complete instruction and accepting the first parcel of the next one. This happens on back-to-back 16-bit instructions and on a block start followed directly by another instruction. The bench provokes it with directed sequences and with random runs where `out_ready` and `in_valid` are held high. It judges the result by checking that `in_ready` stays high and that the next instruction comes out with its own class and data. Flush can also meet a complete instruction whose consumer is ready. The bench checks that the instruction is dropped rather than handed off.

// File: rtl/insn_len_pkg.sv
`timescale 1ns/1ps
// Package: shared length-class type and class-to-parcel-count mapping.
// Assumes the longest instruction is four parcels.
package insn_len_pkg;

    typedef enum logic [2:0] {
        LC_HALF   = 3'd0,
        LC_WORD   = 3'd1,
        LC_WIDE48 = 3'd2,
        LC_WIDE64 = 3'd3,
        LC_BLOCK  = 3'd4
    } len_class_e;

    // Number of parcels that make up an instruction of the given class.
    function automatic logic [2:0] class_parcels(input len_class_e c);
        case (c)
            LC_HALF:   return 3'd1;
            LC_WORD:   return 3'd2;
            LC_WIDE48: return 3'd3;
            LC_WIDE64: return 3'd4;
            LC_BLOCK:  return 3'd1;
            default:   return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/insn_len_classify.sv
`timescale 1ns/1ps
// Module: combinational length classifier.
// Looks at the major opcode in the top bits of a first parcel and returns
// the length class and parcel count. Assumes big-endian instruction order,
// so the opcode always sits in the first parcel. The escape row is the set
// of opcodes whose upper bits are all zero; its pairs pick the class.
module insn_len_classify
    import insn_len_pkg::*;
#(
    parameter int PARCEL_W = 16,
    parameter int OPC_W    = 6
) (
    input  logic [PARCEL_W-1:0] parcel,
    input  logic                esc_en,
    output len_class_e          cls,
    output logic [2:0]          nparc
);
    localparam int ROW_W = OPC_W - 3;

    logic [OPC_W-1:0] opc;
    logic             in_row;

    assign opc    = parcel[PARCEL_W-1 -: OPC_W];
    assign in_row = (opc[OPC_W-1 -: ROW_W] == '0);

    // Decode the opcode pair inside the escape row into a class.
    always_comb begin
        if (esc_en && in_row) begin
            case (opc[2:1])
                2'b00:   cls = LC_HALF;
                2'b01:   cls = LC_WIDE48;
                2'b10:   cls = LC_WIDE64;
                default: cls = LC_BLOCK;
            endcase
        end else begin
            cls = LC_WORD;
        end
    end

    assign nparc = class_parcels(cls);

endmodule

// File: rtl/insn_len_parcel_buf.sv
`timescale 1ns/1ps
// Module: parcel slot store.
// Holds up to SLOTS parcels of one instruction, slot 0 in the top bits.
// A write flagged as first clears every other slot, so the unused tail of
// a short instruction reads as zero. Assumes wr_idx is 0 whenever first is high.
module insn_len_parcel_buf #(
    parameter int PARCEL_W = 16,
    parameter int SLOTS    = 4,
    parameter int IDX_W    = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      first,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [PARCEL_W-1:0]       wr_data,
    output logic [SLOTS*PARCEL_W-1:0] words
);
    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            logic [PARCEL_W-1:0] slot_q;

            // Load this slot on its own index, clear it on a fresh instruction.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (wr_en) begin
                    if (wr_idx == IDX_W'(g)) begin
                        slot_q <= wr_data;
                    end else if (first) begin
                        slot_q <= '0;
                    end
                end
            end

            assign words[(SLOTS-g)*PARCEL_W-1 -: PARCEL_W] = slot_q;
        end
    endgenerate

endmodule

// File: rtl/insn_len_ctrl.sv
`timescale 1ns/1ps
// Module: assembly control.
// Counts accepted parcels against the length decided at the first parcel,
// raises out_valid when the count is reached, and runs both handshakes.
// A hand-off and the next first parcel may share one cycle. Flush wins over
// everything and blocks both handshakes in its cycle.
module insn_len_ctrl
    import insn_len_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             out_ready,
    input  len_class_e       cls_in,
    input  logic [2:0]       need_in,
    output logic             in_ready,
    output logic             out_valid,
    output logic             wr_en,
    output logic             first,
    output logic [IDX_W-1:0] wr_idx,
    output len_class_e       cls_q,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] need_q;
    logic             complete;
    logic             pop;

    // An instruction is complete once every expected parcel is held.
    assign complete  = (cnt_q != '0) && (cnt_q == need_q);
    assign out_valid = complete && !flush;
    assign pop       = out_valid && out_ready;
    assign in_ready  = !flush && (!complete || out_ready);
    assign wr_en     = in_valid && in_ready;
    assign first     = (cnt_q == '0) || pop;
    assign wr_idx    = first ? '0 : cnt_q[IDX_W-1:0];

    // Track the parcel count, the needed length and the latched class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            need_q <= '0;
            cls_q  <= LC_WORD;
        end else if (flush) begin
            cnt_q  <= '0;
        end else if (wr_en) begin
            if (first) begin
                cnt_q  <= CNT_W'(1);
                need_q <= CNT_W'(need_in);
                cls_q  <= cls_in;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end else if (pop) begin
            cnt_q  <= '0;
        end
    end

endmodule

// File: rtl/insn_len_detect.sv
`timescale 1ns/1ps
// Module: top of the instruction length detector.
// Accepts big-endian 16-bit parcels, classifies each instruction by the
// major opcode of its first parcel and emits it left-aligned with its
// length class once complete. Assumes the stream starts on an instruction
// boundary after reset or flush.
module insn_len_detect
    import insn_len_pkg::*;
#(
    parameter int PARCEL_W    = 16,
    parameter int MAX_PARCELS = 4,
    parameter int OPC_W       = 6,
    localparam int INSN_W     = PARCEL_W * MAX_PARCELS,
    localparam int CNT_W      = $clog2(MAX_PARCELS + 1),
    localparam int IDX_W      = $clog2(MAX_PARCELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                esc_en,
    input  logic                flush,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [PARCEL_W-1:0] in_parcel,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [INSN_W-1:0]   out_insn,
    output logic [2:0]          out_class,
    output logic [CNT_W-1:0]    out_len,
    output logic                out_block
);
    len_class_e       cls_new;
    len_class_e       cls_q;
    logic [2:0]       need_new;
    logic             wr_en;
    logic             first;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] cnt_q;

    insn_len_classify #(
        .PARCEL_W (PARCEL_W),
        .OPC_W    (OPC_W)
    ) u_classify (
        .parcel (in_parcel),
        .esc_en (esc_en),
        .cls    (cls_new),
        .nparc  (need_new)
    );

    insn_len_ctrl #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .cls_in    (cls_new),
        .need_in   (need_new),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .wr_en     (wr_en),
        .first     (first),
        .wr_idx    (wr_idx),
        .cls_q     (cls_q),
        .cnt_q     (cnt_q)
    );

    insn_len_parcel_buf #(
        .PARCEL_W (PARCEL_W),
        .SLOTS    (MAX_PARCELS),
        .IDX_W    (IDX_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .first   (first),
        .wr_idx  (wr_idx),
        .wr_data (in_parcel),
        .words   (out_insn)
    );

    assign out_class = cls_q;
    assign out_len   = cnt_q;
    assign out_block = (cls_q == LC_BLOCK);

endmodule

// File: rtl/insn_len_checks.sv
`timescale 1ns/1ps
// Module: protocol and length checker, bound to insn_len_detect.
// Watches only the ports of the top module.
module insn_len_checks #(
    parameter int PARCEL_W = 16,
    parameter int INSN_W   = 64,
    parameter int CNT_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [INSN_W-1:0]   out_insn,
    input logic [2:0]          out_class,
    input logic [CNT_W-1:0]    out_len,
    input logic                out_block
);
    logic [CNT_W-1:0] len_for_class;

    // Parcel count implied by the emitted class.
    always_comb begin
        case (out_class)
            3'd0:    len_for_class = CNT_W'(1);
            3'd1:    len_for_class = CNT_W'(2);
            3'd2:    len_for_class = CNT_W'(3);
            3'd3:    len_for_class = CNT_W'(4);
            default: len_for_class = CNT_W'(1);
        endcase
    end

    // R6: the emitted length matches the class that was latched.
    a_r6_len_class: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == len_for_class));

    // R6: a block start is a single parcel with an empty tail.
    a_r6_block_single: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_block) |-> (out_len == CNT_W'(1) &&
                                      out_insn[INSN_W-PARCEL_W-1:0] == '0));

    // R7: a held instruction blocks new parcels.
    a_r7_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: a held instruction stays unchanged until taken or flushed.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_insn) &&
                                       $stable(out_class) && $stable(out_len))));

    // R8: a hand-off frees the input in the same cycle.
    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !flush) |-> in_ready);

    // R9: flush blocks both handshakes.
    a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!in_ready && !out_valid));

    // R9: nothing is left to emit right after a flush.
    a_r9_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

endmodule

bind insn_len_detect insn_len_checks #(
    .PARCEL_W (PARCEL_W),
    .INSN_W   (INSN_W),
    .CNT_W    (CNT_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_insn  (out_insn),
    .out_class (out_class),
    .out_len   (out_len),
    .out_block (out_block)
);

// File: tb/insn_len_detect_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random instruction streams,
// compared against a queue of expected instructions built by the bench.
module insn_len_detect_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        esc_en = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_parcel = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_insn;
    logic [2:0]  out_class;
    logic [2:0]  out_len;
    logic        out_block;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] pq[$];
    logic [63:0] eq_insn[$];
    logic [2:0]  eq_cls[$];
    logic [2:0]  eq_len[$];
    string       eq_tag[$];

    always #10 clk = ~clk;

    insn_len_detect uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .esc_en    (esc_en),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_parcel (in_parcel),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_insn  (out_insn),
        .out_class (out_class),
        .out_len   (out_len),
        .out_block (out_block)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive inputs after the falling edge, then let them settle.
    task automatic cyc(input logic iv, input logic [15:0] ip, input logic ordy,
                       input logic fl, input logic esc);
        @(negedge clk);
        in_valid  = iv;
        in_parcel = ip;
        out_ready = ordy;
        flush     = fl;
        esc_en    = esc;
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [63:0] insn,
                              input logic [2:0] cls, input logic [2:0] len);
        chk(out_valid == 1'b1, tag, "out_valid", 64'(out_valid), 64'd1);
        chk(out_insn == insn, tag, "out_insn", out_insn, insn);
        chk(out_class == cls, tag, "out_class", 64'(out_class), 64'(cls));
        chk(out_len == len, tag, "out_len", 64'(out_len), 64'(len));
        chk(out_block == (cls == 3'd4), tag, "out_block", 64'(out_block), 64'(cls == 3'd4));
    endtask

    // Length of an instruction of the given class, in parcels.
    function automatic logic [2:0] exp_len(input logic [2:0] c);
        case (c)
            3'd0: return 3'd1;
            3'd1: return 3'd2;
            3'd2: return 3'd3;
            3'd3: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Build one random instruction and queue its parcels and expectation.
    task automatic gen_insn(input bit esc);
        logic [2:0]  c;
        logic [5:0]  opc;
        logic [63:0] raw;
        logic [63:0] ins;
        logic [2:0]  n;
        string       tag;
        raw = {$urandom, $urandom};
        if (esc) begin
            c = 3'($urandom % 5);
        end else begin
            c = 3'd1;
        end
        case (c)
            3'd0: opc = {3'b000, 2'b00, 1'($urandom)};
            3'd2: opc = {3'b000, 2'b01, 1'($urandom)};
            3'd3: opc = {3'b000, 2'b10, 1'($urandom)};
            3'd4: opc = {3'b000, 2'b11, 1'($urandom)};
            default: opc = esc ? 6'(8 + ($urandom % 56)) : 6'($urandom % 64);
        endcase
        raw[63:58] = opc;
        n = exp_len(c);
        ins = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < int'(n)) begin
                pq.push_back(raw[63-16*i -: 16]);
                ins[63-16*i -: 16] = raw[63-16*i -: 16];
            end
        end
        if (!esc)            tag = "R3";
        else if (c == 3'd1)  tag = "R2";
        else if (c == 3'd4)  tag = "R6";
        else                 tag = "R1";
        eq_insn.push_back(ins);
        eq_cls.push_back(c);
        eq_len.push_back(n);
        eq_tag.push_back(tag);
    endtask

    // Run random handshakes until every queued instruction has come out.
    task automatic run_random(input bit esc, input int count,
                              input int vpct, input int rpct);
        logic ivr;
        logic ordy;
        for (int k = 0; k < count; k++) gen_insn(esc);
        while (pq.size() > 0 || eq_insn.size() > 0) begin
            ivr  = (pq.size() > 0) && (($urandom % 100) < vpct);
            ordy = (($urandom % 100) < rpct);
            cyc(ivr, (pq.size() > 0) ? pq[0] : 16'($urandom), ordy, 1'b0, esc);
            if (out_valid && !out_ready) begin
                chk(in_ready == 1'b0, "R7", "in_ready while held", 64'(in_ready), 64'd0);
            end
            if (out_valid && out_ready) begin
                chk(in_ready == 1'b1, "R8", "in_ready on hand-off", 64'(in_ready), 64'd1);
                if (eq_insn.size() == 0) begin
                    chk(1'b0, "R6", "unexpected output", out_insn, 64'd0);
                end else begin
                    expect_out(eq_tag[0], eq_insn[0], eq_cls[0], eq_len[0]);
                    void'(eq_insn.pop_front());
                    void'(eq_cls.pop_front());
                    void'(eq_len.pop_front());
                    void'(eq_tag.pop_front());
                end
            end
            if (in_valid && in_ready) void'(pq.pop_front());
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: state straight out of reset.
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

        // R4: 64-bit class latched at first parcel, escape enable then dropped.
        cyc(1'b1, 16'h1000, 1'b0, 1'b0, 1'b1);
        cyc(1'b1, 16'hAAAA, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 16'hBBBB, 1'b0, 1'b0, 1'b0);
        chk(out_valid == 1'b0, "R6", "valid before last parcel", 64'(out_valid), 64'd0);
        cyc(1'b1, 16'hCCCC, 1'b0, 1'b0, 1'b0);
        chk(out_valid == 1'b0, "R6", "valid before last parcel", 64'(out_valid), 64'd0);
        cyc(1'b1, 16'h7777, 1'b0, 1'b0, 1'b0);
        expect_out("R4", 64'h1000_AAAA_BBBB_CCCC, 3'd3, 3'd4);
        chk(in_ready == 1'b0, "R7", "in_ready while held", 64'(in_ready), 64'd0);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        expect_out("R7", 64'h1000_AAAA_BBBB_CCCC, 3'd3, 3'd4);

        // R3: opcode 2 with escape disabled is a plain 32-bit instruction.
        cyc(1'b1, 16'h0800, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 16'h1234, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
        expect_out("R3", 64'h0800_1234_0000_0000, 3'd1, 3'd2);

        // R2: opcode 8 is just outside the escape row.
        cyc(1'b1, 16'h2000, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 16'h3333, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        expect_out("R2", 64'h2000_3333_0000_0000, 3'd1, 3'd2);

        // R6/R8: block start hand-off shares a cycle with the next first parcel.
        cyc(1'b1, 16'h1C05, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 16'h0001, 1'b1, 1'b0, 1'b1);
        expect_out("R6", 64'h1C05_0000_0000_0000, 3'd4, 3'd1);
        chk(in_ready == 1'b1, "R8", "in_ready on hand-off", 64'(in_ready), 64'd1);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        expect_out("R8", 64'h0001_0000_0000_0000, 3'd0, 3'd1);

        // R9: flush in the middle of a 48-bit instruction.
        cyc(1'b1, 16'h0800, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 16'h1111, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 16'h2222, 1'b1, 1'b1, 1'b1);
        chk(in_ready == 1'b0, "R9", "in_ready during flush", 64'(in_ready), 64'd0);
        chk(out_valid == 1'b0, "R9", "out_valid during flush", 64'(out_valid), 64'd0);
        cyc(1'b1, 16'h0455, 1'b1, 1'b0, 1'b1);
        chk(in_ready == 1'b1, "R9", "in_ready after flush", 64'(in_ready), 64'd1);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        expect_out("R9", 64'h0455_0000_0000_0000, 3'd0, 3'd1);

        // R9: flush against a complete instruction with a ready consumer.
        cyc(1'b1, 16'h0002, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 16'h0, 1'b1, 1'b1, 1'b1);
        chk(out_valid == 1'b0, "R9", "out_valid during flush", 64'(out_valid), 64'd0);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        chk(out_valid == 1'b0, "R9", "discarded instruction", 64'(out_valid), 64'd0);

        // R5: a 48-bit instruction leaves the last parcel slot zero.
        cyc(1'b1, 16'h0DEF, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 16'h4444, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 16'h5555, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
        expect_out("R5", 64'h0DEF_4444_5555_0000, 3'd2, 3'd3);

        // Random streams: stalls, escape off, then full throughput.
        run_random(1'b1, 200, 80, 70);
        run_random(1'b0, 100, 60, 50);
        run_random(1'b1, 200, 100, 100);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule